// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block gives a processor three free-standing 16-bit up-counters behind one small register bus. All three run from the same clock. Each counter can be slowed by a power-of-two prescaler. It runs either freely, rolling over at the top of its range, or in interval mode, where it wraps back to zero at a programmable terminal value. Three compare registers per channel flag the moments the count lands on chosen values. Every event sets a sticky status flag, and each channel has one interrupt line that is driven by the status flags that are enabled.

Software writes registers with a one-cycle write strobe. It reads a register combinationally while the read strobe is high. All copies of one register type sit together in one block of the address map, with one 32-bit word per channel. Reading a channel's status register clears that channel's flags at the end of the read cycle.

Top module: `tri_timer_counter`

## Requirements
- R1: After reset, every channel reads clock control 0, counter control 0x01 (stopped), count 0, terminal value 0xFFFF, all three compare values 0, status 0 and enable mask 0. All interrupt lines are low.
- R2: The register type sits at byte address type*0x0C and the channel at +4*channel. The types, in order 0..8, are: clock control, counter control, count, terminal value, compare 1, compare 2, compare 3, status and enable mask. Any other address, including a misaligned one, reads 0.
- R3: While counter-control bit 0 is 1, the count holds its value. While the bit is 0 and the prescaler is off, the count rises by one on every clock edge.
- R4: Clock-control bit 0 turns the prescaler on, and bits [4:1] hold a value N. With the prescaler on, the count advances once every 2^(N+1) clocks. Writing clock control restarts the prescale phase.
- R5: When the count is 0xFFFF and it advances without an interval wrap, it becomes 0 and status bit 4 is set.
- R6: With counter-control bit 1 set, a count equal to the terminal value wraps to 0 on its next advance and sets status bit 0. This wrap takes priority over the rollover.
- R7: When an advance gives the count a value equal to compare register i (i = 1..3), status bit i is set on the same clock edge.
- R8: Writing 1 to counter-control bit 4 sets the count and the prescale phase to 0 on that edge and sets no flag. The bit reads back as 0, and the other settings are kept.
- R9: A read of the status register clears its flags at the end of the read, except for flags that are set by an event on that same edge. Writes to the status register have no effect.
- R10: A channel's interrupt line is high exactly when at least one of its status flags is set and enabled by the matching bit of its enable mask.
- R11: Each channel's registers, count and interrupt are unaffected by accesses to and activity of the other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the bus and all counters |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe; status clears on the edge it is high |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 3 | One interrupt line per channel |

## Verification
A wrong count or prescale phase shows up as soon as the count register is read. The bench reads each count at a known number of edges after start, so an off-by-one in the advance, the hold or the prescale terminal is visible within one prescale period. A flag that is set on the wrong edge, or cleared at the wrong time, shows up in the next status read and on the interrupt line in the same cycle. A decode error shows up as a wrong reset value, or as a foreign channel's value, in the reset sweep over every address.

// File: rtl/tct_pkg.sv
package tct_pkg;
    localparam int CNT_W   = 16;
    localparam int PSEL_W  = 4;
    localparam int PC_W    = 1 << PSEL_W;
    localparam int CLK_W   = PSEL_W + 1;
    localparam int NMATCH  = 3;
    localparam int NFLAG   = NMATCH + 2;
    localparam int NTYPE   = 9;

    // register type index = position of the type block in the map
    localparam int RT_CLK  = 0;
    localparam int RT_CTL  = 1;
    localparam int RT_CNT  = 2;
    localparam int RT_INTV = 3;
    localparam int RT_M1   = 4;
    localparam int RT_STS  = RT_M1 + NMATCH;
    localparam int RT_IER  = RT_STS + 1;

    // status flag positions
    localparam int FL_INTV = 0;
    localparam int FL_M1   = 1;
    localparam int FL_OVF  = FL_M1 + NMATCH;

    // counter-control bit positions
    localparam int CTL_DIS     = 0;
    localparam int CTL_IMODE   = 1;
    localparam int CTL_RESTART = 4;

    typedef struct packed {
        logic [CLK_W-1:0]             clk;
        logic                         dis;
        logic                         imode;
        logic [CNT_W-1:0]             cnt;
        logic [CNT_W-1:0]             intv;
        logic [NMATCH-1:0][CNT_W-1:0] mat;
        logic [NFLAG-1:0]             sts;
        logic [NFLAG-1:0]             ier;
    } chan_st_t;

    localparam chan_st_t CHAN_RST = '{
        clk:   '0,
        dis:   1'b1,
        imode: 1'b0,
        cnt:   '0,
        intv:  '1,
        mat:   '0,
        sts:   '0,
        ier:   '0
    };
endpackage

// File: rtl/tct_prescaler.sv
module tct_prescaler
    import tct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              clear_i,
    input  logic              en_i,
    input  logic [PSEL_W-1:0] sel_i,
    output logic              tick_o
);
    logic [PC_W-1:0] pcnt_d, pcnt_q;
    logic [PC_W:0]   span;
    logic [PC_W-1:0] term;

    always_comb begin
        span   = {{PC_W{1'b0}}, 1'b1} << ({1'b0, sel_i} + 1'b1);
        term   = PC_W'(span - 1'b1);
        tick_o = en_i ? (run_i && (pcnt_q == term)) : run_i;

        pcnt_d = pcnt_q;
        if (clear_i || !en_i) begin
            pcnt_d = '0;
        end else if (run_i) begin
            pcnt_d = tick_o ? '0 : pcnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_d;
    end

    // two ticks never come back to back while dividing
    assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && en_i) |=> (!tick_o || !en_i));
endmodule

// File: rtl/tct_decode.sv
module tct_decode
    import tct_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 8
)(
    input  logic [ADDR_W-1:0]             addr_i,
    output logic [NUM_CH-1:0][NTYPE-1:0]  hit_o
);
    localparam int STRIDE = NUM_CH * 4;

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            for (int t = 0; t < NTYPE; t++) begin
                hit_o[c][t] = (addr_i == ADDR_W'(t * STRIDE + c * 4));
            end
        end
    end
endmodule

// File: rtl/tct_channel.sv
module tct_channel
    import tct_pkg::*;
#(
    parameter int DATA_W = 32
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NTYPE-1:0]  sel_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    chan_st_t         s_d, s_q;
    logic [NTYPE-1:0] we;
    logic             restart;
    logic             tick;
    logic [NFLAG-1:0] ev;
    logic [CNT_W-1:0] nxt;
    logic             sts_rd;
    logic             unused_wdata;

    assign we           = sel_i & {NTYPE{wr_i}};
    assign restart      = we[RT_CTL] && wdata_i[CTL_RESTART];
    assign sts_rd       = rd_i && sel_i[RT_STS];
    assign unused_wdata = ^wdata_i[DATA_W-1:CNT_W];

    tct_prescaler u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (!s_q.dis),
        .clear_i (restart || we[RT_CLK]),
        .en_i    (s_q.clk[0]),
        .sel_i   (s_q.clk[CLK_W-1:1]),
        .tick_o  (tick)
    );

    always_comb begin
        s_d = s_q;
        ev  = '0;
        nxt = s_q.cnt;

        if (tick) begin
            if (s_q.imode && (s_q.cnt == s_q.intv)) begin
                nxt          = '0;
                ev[FL_INTV]  = 1'b1;
            end else if (&s_q.cnt) begin
                nxt          = '0;
                ev[FL_OVF]   = 1'b1;
            end else begin
                nxt          = s_q.cnt + 1'b1;
            end
            for (int i = 0; i < NMATCH; i++) begin
                if (nxt == s_q.mat[i]) ev[FL_M1 + i] = 1'b1;
            end
        end
        if (restart) begin
            nxt = '0;
            ev  = '0;
        end
        s_d.cnt = nxt;

        if (we[RT_CLK]) s_d.clk = wdata_i[CLK_W-1:0];
        if (we[RT_CTL]) begin
            s_d.dis   = wdata_i[CTL_DIS];
            s_d.imode = wdata_i[CTL_IMODE];
        end
        if (we[RT_INTV]) s_d.intv = wdata_i[CNT_W-1:0];
        for (int i = 0; i < NMATCH; i++) begin
            if (we[RT_M1 + i]) s_d.mat[i] = wdata_i[CNT_W-1:0];
        end
        if (we[RT_IER]) s_d.ier = wdata_i[NFLAG-1:0];

        s_d.sts = (sts_rd ? '0 : s_q.sts) | ev;
    end

    always_comb begin
        rdata_o = '0;
        if (sel_i[RT_CLK])  rdata_o |= DATA_W'(s_q.clk);
        if (sel_i[RT_CTL])  rdata_o |= DATA_W'({s_q.imode, s_q.dis});
        if (sel_i[RT_CNT])  rdata_o |= DATA_W'(s_q.cnt);
        if (sel_i[RT_INTV]) rdata_o |= DATA_W'(s_q.intv);
        for (int i = 0; i < NMATCH; i++) begin
            if (sel_i[RT_M1 + i]) rdata_o |= DATA_W'(s_q.mat[i]);
        end
        if (sel_i[RT_STS])  rdata_o |= DATA_W'(s_q.sts);
        if (sel_i[RT_IER])  rdata_o |= DATA_W'(s_q.ier);
    end

    assign irq_o = |(s_q.sts & s_q.ier);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= CHAN_RST;
        else        s_q <= s_d;
    end

    assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.dis && !restart) |=> $stable(s_q.cnt));

    assert_step_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt != $past(s_q.cnt)) |-> ((s_q.cnt == $past(s_q.cnt) + 1'b1) || (s_q.cnt == '0)));

    assert_ovf_from_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.sts[FL_OVF]) |-> (&$past(s_q.cnt)));

    assert_intv_from_term_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.sts[FL_INTV]) |-> ($past(s_q.imode) && ($past(s_q.cnt) == $past(s_q.intv))));

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_rd && (ev == '0)) |=> (s_q.sts == '0));
endmodule

// File: rtl/tri_timer_counter.sv
module tri_timer_counter
    import tct_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    logic [NUM_CH-1:0][NTYPE-1:0]  hit;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_rdata;

    tct_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
        .addr_i (bus_addr),
        .hit_o  (hit)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tct_channel #(.DATA_W(DATA_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel_i   (hit[g]),
            .wr_i    (bus_wr),
            .rd_i    (bus_rd),
            .wdata_i (bus_wdata),
            .rdata_o (ch_rdata[g]),
            .irq_o   (irq[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) bus_rdata |= ch_rdata[c];
    end

    // at most one register answers any address
    assert_single_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
endmodule

// File: tb/test_tri_timer_counter.sv
module test_tri_timer_counter;
    localparam int CLK_PERIOD = 10;
    localparam int T_CLK = 0, T_CTL = 1, T_CNT = 2, T_INTV = 3, T_M1 = 4,
                   T_M2 = 5, T_M3 = 6, T_STS = 7, T_IER = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;

    int n_chk = 0;
    int n_bad = 0;
    int final_cnt [3];

    tri_timer_counter i_tri_timer_counter (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int ra(int ty, int ch);
        return ty * 12 + ch * 4;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        bus_addr = a[7:0]; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(int a, output int v);
        bus_addr = a[7:0]; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        int v;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset values over the whole map
        for (int ch = 0; ch < 3; ch++) begin
            for (int ty = 0; ty < 9; ty++) begin
                int e;
                e = (ty == T_CTL) ? 1 : (ty == T_INTV) ? 32'hFFFF : 0;
                rd(ra(ty, ch), v);
                chk($sformatf("R1 ch%0d type%0d", ch, ty), v, e);
            end
        end
        chk("R1 irq", int'(irq), 0);

        // R2 unmapped and misaligned addresses
        rd(8'h6C, v); chk("R2 unmapped", v, 0);
        rd(8'h01, v); chk("R2 misaligned", v, 0);

        // R3 R4 R11 sweep channels and prescale settings
        for (int ch = 0; ch < 3; ch++) begin
            for (int m = 0; m < 4; m++) begin
                int cv, p, k;
                cv = (m == 0) ? 0 : (((m - 1) << 1) | 1);
                p  = (m == 0) ? 1 : (2 << (m - 1));
                k  = 9 + 3 * m + ch;
                wr(ra(T_CTL, ch), 32'h11);
                wr(ra(T_CLK, ch), cv);
                wr(ra(T_CTL, ch), 0);
                idle(k);
                rd(ra(T_CNT, ch), v);
                chk($sformatf("R4 ch%0d m%0d run", ch, m), v, k / p);
                wr(ra(T_CTL, ch), 1);
                idle(4);
                rd(ra(T_CNT, ch), v);
                chk($sformatf("R3 ch%0d m%0d hold", ch, m), v, (k + 2) / p);
                rd(ra(T_CLK, ch), v);
                chk($sformatf("R4 ch%0d m%0d cfg", ch, m), v, cv);
                final_cnt[ch] = (k + 2) / p;
            end
        end
        for (int ch = 0; ch < 3; ch++) begin
            rd(ra(T_CNT, ch), v);
            chk($sformatf("R11 ch%0d kept", ch), v, final_cnt[ch]);
        end

        // R6 R10 R9 interval mode on channel 1
        wr(ra(T_M1, 1), 3);
        wr(ra(T_M2, 1), 32'h100);
        wr(ra(T_M3, 1), 32'h200);
        wr(ra(T_INTV, 1), 4);
        wr(ra(T_IER, 1), 1);
        wr(ra(T_CLK, 1), 0);
        wr(ra(T_CTL, 1), 32'h12);
        idle(7);
        rd(ra(T_CNT, 1), v);  chk("R6 wrapped count", v, 2);
        wr(ra(T_CTL, 1), 32'h03);
        chk("R10 irq on", int'(irq[1]), 1);
        chk("R11 irq others", int'(irq[0]) + int'(irq[2]), 0);
        wr(ra(T_IER, 1), 32'h02);
        chk("R10 irq by compare", int'(irq[1]), 1);
        wr(ra(T_IER, 1), 32'h10);
        chk("R10 irq masked", int'(irq[1]), 0);
        rd(ra(T_CTL, 1), v);  chk("R6 ctl readback", v, 3);
        wr(ra(T_STS, 1), 32'h1F);
        rd(ra(T_STS, 1), v);  chk("R9 write ignored", v, 32'h03);
        rd(ra(T_STS, 1), v);  chk("R9 read cleared", v, 0);
        wr(ra(T_IER, 1), 32'h1F);
        chk("R10 irq after clear", int'(irq[1]), 0);

        // R8 restart bit
        wr(ra(T_CTL, 1), 32'h12);
        rd(ra(T_CTL, 1), v);  chk("R8 bit self clears", v, 2);
        rd(ra(T_INTV, 1), v); chk("R8 interval kept", v, 4);
        rd(ra(T_CNT, 1), v);  chk("R8 restarted count", v, 2);
        wr(ra(T_CTL, 1), 1);

        // R7 compare on channel 0
        wr(ra(T_M1, 0), 32'h50);
        wr(ra(T_M2, 0), 6);
        wr(ra(T_M3, 0), 32'h60);
        wr(ra(T_CLK, 0), 0);
        wr(ra(T_CTL, 0), 32'h10);
        rd(ra(T_STS, 0), v);  chk("R7 no flag yet", v, 0);
        idle(4);
        rd(ra(T_STS, 0), v);  chk("R7 before compare", v, 0);
        rd(ra(T_STS, 0), v);  chk("R7 compare 2 flag", v, 32'h04);
        wr(ra(T_CTL, 0), 1);
        rd(ra(T_CNT, 0), v);  chk("R7 count", v, 8);

        // R5 rollover on channel 2 (compare values 0 also fire on the wrap)
        wr(ra(T_CLK, 2), 0);
        wr(ra(T_CTL, 2), 32'h10);
        idle(65535);
        rd(ra(T_CNT, 2), v);  chk("R5 top value", v, 32'hFFFF);
        rd(ra(T_STS, 2), v);  chk("R5 rollover flags", v, 32'h1E);
        rd(ra(T_CNT, 2), v);  chk("R5 after wrap", v, 1);
        rd(ra(T_CNT, 0), v);  chk("R11 ch0 unaffected", v, 8);
        chk("R10 ch2 irq masked", int'(irq[2]), 0);

        summary();
    end
endmodule